// File: doc/BRIEF.md
# Network Controller Power-Up Register Sequencer

This block brings an external network controller chip into a working state after power-up. It replays a fixed list of seven register writes through a shared bus arbiter and a downstream bus controller. A single start pulse, typically from a push button, launches the list. For each entry the block raises a request, waits for the grant and presents a 16-bit word with a one-cycle strobe. It then holds its request until the controller reports that the write has completed.

The chip needs a settling time after its soft reset. The entry that sets the reset bit is therefore followed by a pause of a fixed duration before the entry that clears it is requested. The pause length in cycles comes from a clock-frequency parameter and a pause-duration parameter. Once the last entry is written, an init-done flag rises and stays up until reset. The block also gates the transmit and receive request lines of the other data-path users, so no packet traffic reaches the chip before it is configured.

Top module: `dev_init_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `req_o`, `wr_valid_o`, `init_done_o`, `tx_req_o` and `rx_req_o` are all 0.
- R2: The sequence starts only when `start_i` is high at a clock edge while the block is idle. `req_o` is high in the following cycle. Without a start, `req_o` stays low whatever `gnt_i` and `wr_done_i` do.
- R3: A clock edge with `gnt_i` high while the block is requesting produces exactly one cycle of `wr_valid_o`, in the next cycle. `req_o` stays high from the grant until the edge at which `wr_done_i` is seen.
- R4: `entry_o` carries the register address in bits 15:8 and the value in bits 7:0. The seven strobed words are, in order, 0x1F00, 0x0001, 0x0000, 0xFF81, 0xFE3F, 0x012C, 0x0503, and the last word enables reception in promiscuous mode.
- R5: The next entry is requested only after a `wr_done_i` pulse has followed the strobe. A `wr_done_i` pulse at any other time has no effect.
- R6: After the write of 0x0001 completes, `req_o` stays low for PAUSE_CYC = ceil(CLK_HZ × PAUSE_NS / 10^9) cycles. Only then is the 0x0000 entry requested.
- R7: `init_done_o` rises in the cycle after `wr_done_i` completes the seventh entry and stays high until reset.
- R8: `start_i` pulses while a sequence is running, or after it has finished, are ignored. They do not restart the list, repeat an entry or raise `req_o` after completion.
- R9: `tx_req_o` equals `user_tx_req_i` and `rx_req_o` equals `user_rx_req_i` when `init_done_o` is high. Both outputs are 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the power-up list |
| req_o | output | 1 | Request to the bus arbiter |
| gnt_i | input | 1 | Grant from the bus arbiter |
| wr_valid_o | output | 1 | One-cycle strobe: `entry_o` is to be written |
| entry_o | output | 16 | {register address, value} of the current entry |
| wr_done_i | input | 1 | Write-complete pulse from the bus controller |
| init_done_o | output | 1 | Chip configured; sticky until reset |
| user_tx_req_i | input | 1 | Transmit request from a data-path user |
| user_rx_req_i | input | 1 | Receive request from a data-path user |
| tx_req_o | output | 1 | Gated transmit request |
| rx_req_o | output | 1 | Gated receive request |

## Verification
The bench builds the block with CLK_HZ = 1,000,000 and PAUSE_NS = 10,000, which gives a pause of 10 cycles. At that length a full sequence, a reset in the middle of a sequence and a complete rerun all fit in a few hundred cycles. The bench grant and completion responder varies its latency from entry to entry. This moves the pause boundary, the strobe and the completion pulse against each other. With the short pause, stray start and completion pulses can also be placed inside the pause window.

// File: rtl/dis_pkg.sv
package dis_pkg;

  localparam int unsigned NUM_STEPS = 7;
  localparam int unsigned STEP_IW   = $clog2(NUM_STEPS);

  typedef struct packed {
    logic [7:0] reg_addr;
    logic [7:0] reg_val;
    logic       hold_after;   // settle pause follows this write
  } init_step_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_ISSUE, ST_WAIT, ST_PAUSE, ST_DONE
  } seq_state_t;

  // Power-up recipe: switch on, soft reset, release reset, clear flags, enable rx.
  function automatic init_step_t step_at(input logic [STEP_IW-1:0] i);
    init_step_t s;
    s.hold_after = 1'b0;
    case (i)
      3'd0:    begin s.reg_addr = 8'h1F; s.reg_val = 8'h00; end
      3'd1:    begin s.reg_addr = 8'h00; s.reg_val = 8'h01; s.hold_after = 1'b1; end
      3'd2:    begin s.reg_addr = 8'h00; s.reg_val = 8'h00; end
      3'd3:    begin s.reg_addr = 8'hFF; s.reg_val = 8'h81; end
      3'd4:    begin s.reg_addr = 8'hFE; s.reg_val = 8'h3F; end
      3'd5:    begin s.reg_addr = 8'h01; s.reg_val = 8'h2C; end
      default: begin s.reg_addr = 8'h05; s.reg_val = 8'h03; end
    endcase
    return s;
  endfunction

  function automatic logic [15:0] pack_word(input init_step_t s);
    return {s.reg_addr, s.reg_val};
  endfunction

  // Cycles covering a pause of ns nanoseconds at clk_hz, rounded up, at least 1.
  function automatic longint unsigned pause_cycles(input longint unsigned clk_hz,
                                                   input longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/init_table.sv
module init_table
  import dis_pkg::*;
(
  input  logic [STEP_IW-1:0] idx_i,
  output logic [15:0]        word_o,
  output logic               hold_o,
  output logic               last_o
);
  init_step_t s;
  always_comb begin
    s      = step_at(idx_i);
    word_o = pack_word(s);
    hold_o = s.hold_after;
    last_o = (idx_i == STEP_IW'(NUM_STEPS - 1));
  end
endmodule

// File: rtl/pause_timer.sv
module pause_timer #(
  parameter int unsigned CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o,
  output logic expired_o
);
  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load_i) begin
      cnt    <= CW'(CYCLES - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign active_o  = active;
  assign expired_o = active && (cnt == '0);
endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import dis_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               gnt_i,
  input  logic               wr_done_i,
  input  logic               hold_i,
  input  logic               last_i,
  input  logic               pause_expired_i,
  output logic [STEP_IW-1:0] idx_o,
  output logic               pause_load_o,
  output logic               req_o,
  output logic               strobe_o,
  output logic               done_o,
  output logic               advance_o
);
  seq_state_t        state, nxt;
  logic [STEP_IW-1:0] idx;

  always_comb begin
    nxt          = state;
    pause_load_o = 1'b0;
    advance_o    = 1'b0;
    case (state)
      ST_IDLE:  if (start_i) nxt = ST_REQ;
      ST_REQ:   if (gnt_i)   nxt = ST_ISSUE;
      ST_ISSUE: nxt = ST_WAIT;
      ST_WAIT:  if (wr_done_i) begin
                  if (last_i)      nxt = ST_DONE;
                  else if (hold_i) begin nxt = ST_PAUSE; pause_load_o = 1'b1; end
                  else             begin nxt = ST_REQ;   advance_o    = 1'b1; end
                end
      ST_PAUSE: if (pause_expired_i) begin nxt = ST_REQ; advance_o = 1'b1; end
      default:  nxt = state;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= nxt;
      if (advance_o) idx <= idx + 1'b1;
    end
  end

  assign idx_o    = idx;
  assign req_o    = (state == ST_REQ) || (state == ST_ISSUE) || (state == ST_WAIT);
  assign strobe_o = (state == ST_ISSUE);
  assign done_o   = (state == ST_DONE);
endmodule

// File: rtl/port_gate.sv
module port_gate #(
  parameter int unsigned N = 2
) (
  input  logic         open_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    assign req_o[g] = req_i[g] & open_i;
  end
endmodule

// File: rtl/dev_init_seq.sv
module dev_init_seq
  import dis_pkg::*;
#(
  parameter longint unsigned CLK_HZ   = 50_000_000,
  parameter longint unsigned PAUSE_NS = 10_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        req_o,
  input  logic        gnt_i,
  output logic        wr_valid_o,
  output logic [15:0] entry_o,
  input  logic        wr_done_i,
  output logic        init_done_o,
  input  logic        user_tx_req_i,
  input  logic        user_rx_req_i,
  output logic        tx_req_o,
  output logic        rx_req_o
);
  localparam int unsigned PAUSE_CYC = int'(pause_cycles(CLK_HZ, PAUSE_NS));

  // Named internal events, visible to the bound checker.
  logic [STEP_IW-1:0] step_idx;
  logic               step_hold, step_last;
  logic               pause_load, pause_active, pause_expired;
  logic               step_advance;
  logic [31:0]        pause_len_w;

  assign pause_len_w = 32'(PAUSE_CYC);

  init_table u_table (
    .idx_i(step_idx), .word_o(entry_o), .hold_o(step_hold), .last_o(step_last)
  );

  pause_timer #(.CYCLES(PAUSE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(pause_load),
    .active_o(pause_active), .expired_o(pause_expired)
  );

  init_step_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .gnt_i(gnt_i),
    .wr_done_i(wr_done_i), .hold_i(step_hold), .last_i(step_last),
    .pause_expired_i(pause_expired), .idx_o(step_idx),
    .pause_load_o(pause_load), .req_o(req_o), .strobe_o(wr_valid_o),
    .done_o(init_done_o), .advance_o(step_advance)
  );

  port_gate #(.N(2)) u_gate (
    .open_i(init_done_o),
    .req_i({user_rx_req_i, user_tx_req_i}),
    .req_o({rx_req_o, tx_req_o})
  );
endmodule

// File: rtl/dev_init_seq_chk.sv
module dev_init_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_o,
  input logic        gnt_i,
  input logic        wr_valid_o,
  input logic [15:0] entry_o,
  input logic        wr_done_i,
  input logic        init_done_o,
  input logic        user_tx_req_i,
  input logic        user_rx_req_i,
  input logic        tx_req_o,
  input logic        rx_req_o,
  input logic        pause_active,
  input logic [31:0] pause_len_w
);
  // Cycles since the reset-bit write completed, saturating.
  logic [31:0] gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= '0;
    else if (req_o && wr_done_i && entry_o == 16'h0001) gap <= '0;
    else if (gap != 32'hFFFF_FFFF) gap <= gap + 1'b1;
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  // R3
  strobe_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> $past(gnt_i));
  // R3
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> req_o);
  // R6
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && entry_o == 16'h0000) |-> (gap >= pause_len_w));
  // R6
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pause_active |-> !req_o);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |=> init_done_o);
  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done_o |-> !req_o);
  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_o |-> (init_done_o && user_tx_req_i)) and
    (rx_req_o |-> (init_done_o && user_rx_req_i)));
endmodule

bind dev_init_seq dev_init_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_o(req_o), .gnt_i(gnt_i),
  .wr_valid_o(wr_valid_o), .entry_o(entry_o), .wr_done_i(wr_done_i),
  .init_done_o(init_done_o), .user_tx_req_i(user_tx_req_i),
  .user_rx_req_i(user_rx_req_i), .tx_req_o(tx_req_o), .rx_req_o(rx_req_o),
  .pause_active(pause_active), .pause_len_w(pause_len_w)
);

// File: tb/sim_dev_init_seq.sv
`timescale 1ns/1ps
module sim_dev_init_seq;
  localparam longint unsigned HZ = 1_000_000;
  localparam longint unsigned NS = 10_000;
  localparam int P = 10;   // ceil(1e6 * 1e4 / 1e9)

  logic clk = 0, rst_n = 0;
  logic start_i = 0, gnt_i = 0, wr_done_i = 0, utx = 0, urx = 0;
  logic req_o, wr_valid_o, init_done_o, tx_req_o, rx_req_o;
  logic [15:0] entry_o;

  always #10 clk = ~clk;   // 50 MHz

  dev_init_seq #(.CLK_HZ(HZ), .PAUSE_NS(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .req_o(req_o), .gnt_i(gnt_i),
    .wr_valid_o(wr_valid_o), .entry_o(entry_o), .wr_done_i(wr_done_i),
    .init_done_o(init_done_o), .user_tx_req_i(utx), .user_rx_req_i(urx),
    .tx_req_o(tx_req_o), .rx_req_o(rx_req_o));

  int n_cmp = 0, n_bad = 0;
  logic [15:0] recipe [7] = '{16'h1F00, 16'h0001, 16'h0000, 16'hFF81,
                              16'hFE3F, 16'h012C, 16'h0503};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase names as words, a countdown, an entry pointer.
  string ph = "idle";
  int    k = 0, wait_left = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ph <= "idle"; k <= 0; wait_left <= 0; end
    else if (ph == "idle")  begin if (start_i) ph <= "ask"; end
    else if (ph == "ask")   begin if (gnt_i) ph <= "fire"; end
    else if (ph == "fire")  ph <= "hold";
    else if (ph == "hold")  begin
      if (wr_done_i) begin
        if (k == 6) ph <= "ready";
        else if (recipe[k] == 16'h0001) begin ph <= "settle"; wait_left <= P; end
        else begin ph <= "ask"; k <= k + 1; end
      end
    end
    else if (ph == "settle") begin
      if (wait_left == 1) begin ph <= "ask"; k <= k + 1; end
      else wait_left <= wait_left - 1;
    end
  end

  // Compare every cycle, away from the active edge.
  int strobes = 0;
  int last_done_at = 0, cyc = 0;
  logic [15:0] seen [$];
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit er, ev, ed;
      er = (ph == "ask" || ph == "fire" || ph == "hold");
      ev = (ph == "fire");
      ed = (ph == "ready");
      check(req_o == er, "R2/R3/R5/R6/R8 req_o", req_o, er);
      check(wr_valid_o == ev, "R3 wr_valid_o", wr_valid_o, ev);
      check(init_done_o == ed, "R7 init_done_o", init_done_o, ed);
      check(tx_req_o == (utx & ed), "R9 tx_req_o", tx_req_o, utx & ed);
      check(rx_req_o == (urx & ed), "R9 rx_req_o", rx_req_o, urx & ed);
      if (wr_valid_o) begin
        check(entry_o == recipe[k], "R4 entry_o", entry_o, recipe[k]);
        seen.push_back(entry_o);
        if (entry_o == 16'h0000)
          check(cyc - last_done_at >= P, "R6 settle gap", cyc - last_done_at, P);
      end
    end
  end

  // Bus responder with per-entry latency; stray completion pulses when allowed.
  bit resp_en = 0, stray = 0;
  int rs = 0, cnt = 0, nent = 0;
  always @(negedge clk) begin
    #2;
    gnt_i = 0; wr_done_i = 0;
    if (!rst_n || !resp_en) begin rs = 0; cnt = 0; end
    else case (rs)
      0: if (req_o) begin
           if (cnt >= nent % 3) begin gnt_i = 1; rs = 1; cnt = 0; end
           else cnt++;
         end else if (stray && !init_done_o) wr_done_i = 1;
      1: if (wr_valid_o) rs = 2;
      default: begin
           if (cnt >= nent % 4) begin
             wr_done_i = 1; rs = 0; cnt = 0; nent++;
             if (entry_o == 16'h0001) last_done_at = cyc + 1;
           end else cnt++;
         end
    endcase
  end

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
    #4;
  endtask

  task automatic pulse_start;
    @(negedge clk); #4; start_i = 1; @(negedge clk); #4; start_i = 0;
  endtask

  initial begin
    fork
      begin #2_000_000; check(0, "watchdog", 0, 1); end
      begin
        // R1: reset state
        ticks(3);
        check(!req_o && !wr_valid_o && !init_done_o && !tx_req_o && !rx_req_o,
              "R1 outputs in reset", req_o, 0);
        @(negedge clk); #4; rst_n = 1;
        ticks(1);
        check(!req_o && !init_done_o, "R1 first cycle", req_o, 0);
        // R2/R5: grant and done without start do nothing
        utx = 1; urx = 1;
        gnt_i = 1; wr_done_i = 1; ticks(4); gnt_i = 0; wr_done_i = 0;
        check(!req_o, "R2 no request without start", req_o, 0);
        check(!tx_req_o && !rx_req_o, "R9 gated before init", tx_req_o, 0);
        // full run, stray done pulses and stray starts mid-run
        resp_en = 1; stray = 1;
        pulse_start;
        check(req_o, "R2 request after start", req_o, 1);
        ticks(6); pulse_start;               // R8 ignored while running
        wait (last_done_at != 0); ticks(3); pulse_start;  // inside pause
        wait (init_done_o); ticks(2);
        check(seen.size() == 7, "R4 entry count", seen.size(), 7);
        foreach (seen[i]) check(seen[i] == recipe[i], "R4 order", seen[i], recipe[i]);
        check(tx_req_o && rx_req_o, "R9 open after init", tx_req_o, 1);
        utx = 0; ticks(1);
        check(!tx_req_o && rx_req_o, "R9 follows user", tx_req_o, 0);
        pulse_start; ticks(5);               // R8 ignored after done
        check(!req_o && init_done_o, "R7/R8 sticky done", init_done_o, 1);
        // reset mid-run, then a clean rerun
        @(negedge clk); #4; rst_n = 0; ticks(2); rst_n = 1; ticks(1);
        check(!init_done_o && !tx_req_o, "R1 reset clears done", init_done_o, 0);
        seen.delete(); last_done_at = 0; stray = 0; nent = 1;
        pulse_start; ticks(20);
        @(negedge clk); #4; rst_n = 0; ticks(1); rst_n = 1; ticks(1);
        check(!req_o, "R1 reset mid-run", req_o, 0);
        seen.delete();
        pulse_start;
        wait (init_done_o); ticks(2);
        check(seen.size() == 7, "R4 rerun count", seen.size(), 7);
        check(init_done_o, "R7 rerun done", init_done_o, 1);
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule